// File: doc/BRIEF.md
# Virtual Interrupt Flag Control Unit

This unit holds the interrupt-enable portion of a processor's flags logic and decides what happens to interrupt-flag instructions, hardware interrupt requests and software interrupts. It is used when virtual-mode extensions exist. When the extensions are switched on and the processor runs a virtual-mode program, that program's clear-interrupt, set-interrupt and flag-pop operations act on a shadow bit (VIF) and do not touch the real enable bit (IF). The supervisor therefore keeps receiving maskable hardware interrupts. It can hold an interrupt back for the program by setting the pending bit (VIP) in the flags image it restores.

A later attempt by the program to enable interrupts while VIP is set is blocked, and the attempt raises a one-cycle general-protection fault pulse. Software interrupts are never masked by either flag. Each vector is sent either to the virtual-mode vector table or to the protected descriptor table, as one bit per vector in a redirection map selects. Instruction decode, stack frames and table lookups are done elsewhere. The unit sees only decoded strobes and the bitmap.

Top module: `vif_ctrl`

## Requirements
- R1: A synchronous active-low reset clears IF, VIF, VIP and the fault output.
- R2: When extensions are off or the unit is outside virtual mode ("native"), clear-interrupt clears IF, set-interrupt sets IF, and a flag pop loads IF from its data bit. VIF and VIP keep their values.
- R3: When extensions are on and the unit is in virtual mode ("virtual"), clear-interrupt clears VIF, set-interrupt sets VIF, and a flag pop loads VIF. IF keeps its value. No fault is raised unless R5 applies.
- R4: The flag-read output returns VIF in virtual mode and IF in native mode.
- R5: In virtual mode, an attempt to make VIF 1 while VIP is 1 leaves VIF unchanged. The attempt is either set-interrupt or a pop with data 1. It drives the fault output high for the cycle after the edge that sampled the attempt. Clearing VIF is never blocked.
- R6: A hardware interrupt request is taken to the supervisor exactly when IF is 1, whatever the values of VIF and VIP. Otherwise it is reported as ignored. Both outputs are combinational.
- R7: A software-interrupt strobe always produces a fire output in the same cycle, whatever the values of IF, VIF and VIP.
- R8: In virtual mode, the software interrupt is routed by redirection-map bit number `vector`. A 0 selects the virtual-mode vector table, reported as route output 0. A 1 selects the protected descriptor table, reported as 1. In native mode the route is always 1.
- R9: A restore strobe loads IF, VIF and VIP from its three data inputs. It takes priority over clear, set and pop strobes in the same cycle and never faults.
- R10: The fault output is low in any cycle that follows an edge at which no blocked enable attempt was sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vmode | input | 1 | Processor is running a virtual-mode program |
| ext_en | input | 1 | Virtual-mode extensions enabled |
| clr_stb | input | 1 | Decoded clear-interrupt instruction |
| set_stb | input | 1 | Decoded set-interrupt instruction |
| pop_stb | input | 1 | Decoded flag pop by the running program |
| pop_ie | input | 1 | Interrupt-enable bit carried by the pop |
| rest_stb | input | 1 | Supervisor flags restore |
| rest_if | input | 1 | IF value to restore |
| rest_vif | input | 1 | VIF value to restore |
| rest_vip | input | 1 | VIP value to restore |
| irq_req | input | 1 | External maskable interrupt request |
| swi_stb | input | 1 | Software interrupt instruction |
| swi_vec | input | 8 | Software interrupt vector |
| redir_map | input | 256 | Per-vector redirection bits |
| if_o | output | 1 | Current IF |
| vif_o | output | 1 | Current VIF |
| vip_o | output | 1 | Current VIP |
| flag_rd | output | 1 | Interrupt-enable value seen by flag reads |
| gp_fault | output | 1 | General-protection fault pulse |
| irq_take | output | 1 | Hardware interrupt goes to the supervisor |
| irq_ignore | output | 1 | Hardware interrupt is not taken |
| swi_fire | output | 1 | Software interrupt proceeds |
| swi_to_idt | output | 1 | 1: protected descriptor table, 0: virtual-mode vector table |

## Verification
The bench restores every combination of mode, extension enable, IF, VIF and VIP, then applies each of the four flag operations and compares the result with an arithmetic model. This catches a design that lets a virtual program clear the real IF and silently masks hardware interrupts. It also catches one that lets set-interrupt through while VIP is set, or one whose fault pulse lingers or never appears. The bench also checks that popping a 1 is blocked like set-interrupt and that clearing is never blocked. Every vector is swept against a computed redirection map in both modes, which exposes an inverted or mis-indexed route. Hardware and software interrupts are tried against all flag states, so a design that gates either one on VIF shows up.

// File: rtl/vif_pkg.sv
// Shared types for the virtual interrupt flag unit.
// Assumes one flag operation per cycle after priority encoding.
package vif_pkg;

    localparam int VEC_W_DEF = 8;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_REST = 3'd1,
        OP_CLR  = 3'd2,
        OP_SET  = 3'd3,
        OP_POP  = 3'd4
    } flag_op_e;

    typedef struct packed {
        logic ie;    // real interrupt enable
        logic vie;   // shadow interrupt enable
        logic vpend; // held interrupt pending
    } flags_t;

endpackage

// File: rtl/vif_op_decode.sv
// Reduces the flag strobes to one operation.
// Assumes the restore strobe outranks program strobes; among program
// strobes clear outranks set, and set outranks pop.
module vif_op_decode
    import vif_pkg::*;
(
    input  logic     rest_stb,
    input  logic     clr_stb,
    input  logic     set_stb,
    input  logic     pop_stb,
    output flag_op_e op
);

    // Fixed-priority selection of the operation for this cycle.
    always_comb begin
        if (rest_stb)     op = OP_REST;
        else if (clr_stb) op = OP_CLR;
        else if (set_stb) op = OP_SET;
        else if (pop_stb) op = OP_POP;
        else              op = OP_NONE;
    end

endmodule

// File: rtl/vif_flag_regs.sv
// Holds IF, VIF and VIP. It routes program writes to VIF in virtual mode,
// blocks VIF enables while VIP is set and registers the fault pulse.
// Assumes the op input is already priority-encoded.
module vif_flag_regs
    import vif_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     virt,
    input  flag_op_e op,
    input  logic     pop_ie,
    input  flags_t   rest_val,
    output flags_t   cur,
    output logic     flag_rd,
    output logic     gp_fault
);

    flags_t nxt;
    logic   fault_n;
    logic   wr_val;

    // Value a program write would place in the enable position.
    always_comb begin
        wr_val = 1'b0;
        if (op == OP_SET)      wr_val = 1'b1;
        else if (op == OP_POP) wr_val = pop_ie;
    end

    // Next-state and fault decision for the current operation.
    always_comb begin
        nxt     = cur;
        fault_n = 1'b0;
        case (op)
            OP_REST: nxt = rest_val;
            OP_CLR, OP_SET, OP_POP: begin
                if (!virt)                     nxt.ie  = wr_val;
                else if (wr_val && cur.vpend)  fault_n = 1'b1;
                else                           nxt.vie = wr_val;
            end
            default: nxt = cur;
        endcase
    end

    // Flag state and fault pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= '0;
            gp_fault <= 1'b0;
        end else begin
            cur      <= nxt;
            gp_fault <= fault_n;
        end
    end

    // Enable position as seen by flag reads.
    assign flag_rd = virt ? cur.vie : cur.ie;

    a_r5_enable_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (virt && cur.vpend && (op == OP_SET)) |=> (gp_fault && $stable(cur.vie)));

    a_r3_if_held_virtual: assert property (@(posedge clk) disable iff (!rst_n)
        (virt && (op inside {OP_CLR, OP_SET, OP_POP})) |=> $stable(cur.ie));

    a_r2_shadow_held_native: assert property (@(posedge clk) disable iff (!rst_n)
        (!virt && (op inside {OP_CLR, OP_SET, OP_POP})) |=> ($stable(cur.vie) && $stable(cur.vpend)));

    a_r10_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE) |=> !gp_fault);

    a_r9_restore_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_REST) |=> !gp_fault);

endmodule

// File: rtl/vif_int_route.sv
// Decides hardware interrupt delivery from IF alone and routes software
// interrupts through the per-vector redirection map.
// Assumes the map holds one bit per vector, indexed by vector number.
module vif_int_route #(
    parameter int VEC_W = 8,
    localparam int NVEC = 1 << VEC_W
) (
    input  logic             virt,
    input  logic             ie,
    input  logic             irq_req,
    input  logic             swi_stb,
    input  logic [VEC_W-1:0] swi_vec,
    input  logic [NVEC-1:0]  redir_map,
    output logic             irq_take,
    output logic             irq_ignore,
    output logic             swi_fire,
    output logic             swi_to_idt
);

    // Hardware interrupt delivery depends only on the real enable.
    always_comb begin
        irq_take   = irq_req & ie;
        irq_ignore = irq_req & ~ie;
    end

    // Software interrupts are never masked; the route comes from the map.
    always_comb begin
        swi_fire   = swi_stb;
        swi_to_idt = virt ? redir_map[swi_vec] : 1'b1;
    end

endmodule

// File: rtl/vif_ctrl.sv
// Top of the virtual interrupt flag unit. It wires the strobe decoder,
// the flag registers and the interrupt router together.
// Assumes the strobes are single-cycle, decoded elsewhere.
module vif_ctrl
    import vif_pkg::*;
#(
    parameter int VEC_W = VEC_W_DEF,
    localparam int NVEC = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vmode,
    input  logic             ext_en,
    input  logic             clr_stb,
    input  logic             set_stb,
    input  logic             pop_stb,
    input  logic             pop_ie,
    input  logic             rest_stb,
    input  logic             rest_if,
    input  logic             rest_vif,
    input  logic             rest_vip,
    input  logic             irq_req,
    input  logic             swi_stb,
    input  logic [VEC_W-1:0] swi_vec,
    input  logic [NVEC-1:0]  redir_map,
    output logic             if_o,
    output logic             vif_o,
    output logic             vip_o,
    output logic             flag_rd,
    output logic             gp_fault,
    output logic             irq_take,
    output logic             irq_ignore,
    output logic             swi_fire,
    output logic             swi_to_idt
);

    logic     virt;
    flag_op_e op;
    flags_t   cur;
    flags_t   rest_val;

    // Virtual handling applies only with extensions on in virtual mode.
    assign virt     = vmode & ext_en;
    assign rest_val = '{ie: rest_if, vie: rest_vif, vpend: rest_vip};

    vif_op_decode u_dec (
        .rest_stb (rest_stb),
        .clr_stb  (clr_stb),
        .set_stb  (set_stb),
        .pop_stb  (pop_stb),
        .op       (op)
    );

    vif_flag_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .virt     (virt),
        .op       (op),
        .pop_ie   (pop_ie),
        .rest_val (rest_val),
        .cur      (cur),
        .flag_rd  (flag_rd),
        .gp_fault (gp_fault)
    );

    vif_int_route #(.VEC_W(VEC_W)) u_route (
        .virt       (virt),
        .ie         (cur.ie),
        .irq_req    (irq_req),
        .swi_stb    (swi_stb),
        .swi_vec    (swi_vec),
        .redir_map  (redir_map),
        .irq_take   (irq_take),
        .irq_ignore (irq_ignore),
        .swi_fire   (swi_fire),
        .swi_to_idt (swi_to_idt)
    );

    assign if_o  = cur.ie;
    assign vif_o = cur.vie;
    assign vip_o = cur.vpend;

    a_r6_take_needs_if: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> if_o);

    a_r8_native_to_idt: assert property (@(posedge clk) disable iff (!rst_n)
        (swi_fire && !virt) |-> swi_to_idt);

endmodule

// File: tb/sim_vif_ctrl.sv
module sim_vif_ctrl;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         vmode, ext_en, clr_stb, set_stb, pop_stb, pop_ie;
    logic         rest_stb, rest_if, rest_vif, rest_vip, irq_req, swi_stb;
    logic [7:0]   swi_vec;
    logic [255:0] redir_map;
    logic         if_o, vif_o, vip_o, flag_rd, gp_fault;
    logic         irq_take, irq_ignore, swi_fire, swi_to_idt;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    vif_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .vmode(vmode), .ext_en(ext_en),
        .clr_stb(clr_stb), .set_stb(set_stb), .pop_stb(pop_stb), .pop_ie(pop_ie),
        .rest_stb(rest_stb), .rest_if(rest_if), .rest_vif(rest_vif), .rest_vip(rest_vip),
        .irq_req(irq_req), .swi_stb(swi_stb), .swi_vec(swi_vec), .redir_map(redir_map),
        .if_o(if_o), .vif_o(vif_o), .vip_o(vip_o), .flag_rd(flag_rd), .gp_fault(gp_fault),
        .irq_take(irq_take), .irq_ignore(irq_ignore), .swi_fire(swi_fire),
        .swi_to_idt(swi_to_idt)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic map_bit(input int v);
        return logic'(((v * 37) >> 3) ^ (v >> 6)) & 1'b1;
    endfunction

    task automatic idle();
        clr_stb = 0; set_stb = 0; pop_stb = 0; pop_ie = 0; rest_stb = 0;
        irq_req = 0; swi_stb = 0;
    endtask

    initial begin
        #3000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0; vmode = 0; ext_en = 0; idle();
        rest_if = 0; rest_vif = 0; rest_vip = 0; swi_vec = 0; redir_map = '0;
        for (int i = 0; i < 256; i++) redir_map[i] = map_bit(i);
        // R1: drive nonzero restore during reset; state must stay cleared.
        @(negedge clk); rest_stb = 1; rest_if = 1; rest_vif = 1; rest_vip = 1;
        @(negedge clk);
        chk("R1 reset flags", {5'd0, if_o, vif_o, vip_o}, 8'd0);
        chk("R1 reset fault", {7'd0, gp_fault}, 8'd0);
        idle(); rst_n = 1;
        @(negedge clk);

        // Sweep every mode and flag state with each flag operation.
        for (int s = 0; s < 32; s++) begin
            for (int op = 0; op < 4; op++) begin
                logic v86, en, fi, fv, fp, virt, setv;
                logic ei, ev, ep, eg;
                v86 = s[4]; en = s[3]; fi = s[2]; fv = s[1]; fp = s[0];
                virt = v86 & en;
                vmode = v86; ext_en = en;
                rest_stb = 1; rest_if = fi; rest_vif = fv; rest_vip = fp;
                // R9: a program strobe in the restore cycle is overridden.
                set_stb = 1;
                @(negedge clk);
                idle();
                chk("R9 restore", {5'd0, if_o, vif_o, vip_o}, {5'd0, fi, fv, fp});
                chk("R9 no fault", {7'd0, gp_fault}, 8'd0);
                chk("R4 flag read", {7'd0, flag_rd}, {7'd0, virt ? fv : fi});
                // R6: delivery follows IF only.
                irq_req = 1; #1;
                chk("R6 take", {6'd0, irq_take, irq_ignore}, {6'd0, fi, ~fi});
                irq_req = 0;
                // R7: software interrupt is never masked.
                swi_stb = 1; swi_vec = 8'(s * 7 + op); #1;
                chk("R7 fire", {7'd0, swi_fire}, 8'd1);
                swi_stb = 0;
                // Apply the flag operation.
                case (op)
                    0: clr_stb = 1;
                    1: set_stb = 1;
                    2: begin pop_stb = 1; pop_ie = 0; end
                    default: begin pop_stb = 1; pop_ie = 1; end
                endcase
                setv = (op == 1) || (op == 3);
                ei = fi; ev = fv; ep = fp; eg = 0;
                if (!virt) ei = setv;
                else if (setv && fp) eg = 1;
                else ev = setv;
                @(negedge clk);
                idle();
                if (!virt) chk("R2 native op", {5'd0, if_o, vif_o, vip_o}, {5'd0, ei, ev, ep});
                else       chk("R3 virtual op", {5'd0, if_o, vif_o, vip_o}, {5'd0, ei, ev, ep});
                chk("R5 fault pulse", {7'd0, gp_fault}, {7'd0, eg});
                @(negedge clk);
                chk("R10 fault clears", {7'd0, gp_fault}, 8'd0);
                chk("R4 read after op", {7'd0, flag_rd}, {7'd0, virt ? ev : ei});
            end
        end

        // R8: route sweep over every vector in virtual and native mode.
        for (int m = 0; m < 2; m++) begin
            vmode = 1; ext_en = logic'(m == 0);
            for (int v = 0; v < 256; v++) begin
                swi_stb = 1; swi_vec = 8'(v); #1;
                chk("R8 route", {6'd0, swi_fire, swi_to_idt},
                    {6'd0, 1'b1, (m == 0) ? map_bit(v) : 1'b1});
                #1;
            end
        end
        swi_stb = 0;

        // R1: reset after activity clears everything again.
        @(negedge clk);
        rest_stb = 1; rest_if = 1; rest_vif = 1; rest_vip = 1;
        @(negedge clk); idle(); rst_n = 0;
        @(negedge clk);
        chk("R1 re-reset", {4'd0, if_o, vif_o, vip_o, gp_fault}, 8'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule